// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block collects a parameterised set of external interrupt sources and routes them to a number of processor contexts. A context is one privilege level on one hardware thread. Each source carries a programmable priority. Each context has its own set of enable bits and its own priority threshold. The block drives one interrupt line per context. That line stays high while at least one source is pending, enabled for that context and above its threshold.

Software serves an interrupt in two steps. It first reads the claim register of its context. The read returns the best eligible source ID and takes that source out of the pending set. When the handler finishes, software writes the same ID back to the same register. Until that write arrives, the source cannot become pending again. Each source is built either as edge-sensitive or as level-sensitive. A context slot can be built as absent; its line then stays low and its registers do nothing.

Top module: `irq_router`

## Requirements
- R1: After reset every interrupt output is low, every priority, enable and threshold register reads 0, and the pending word reads 0.
- R2: Among the eligible sources of a context, the one with the highest priority wins. When priorities are equal, the lowest source ID wins. Input bit k of `src_i` is source ID k+1, and ID 0 means "none".
- R3: A source is eligible for a context only if its priority is strictly greater than that context's threshold. A priority equal to the threshold is masked, and priority 0 never interrupts.
- R4: Enables are per context. Bit n of a context's enable word (offset 0x2000 + 0x80*context) enables source ID n for that context only.
- R5: A read of a context's claim register (offset 0x200004 + 0x1000*context) returns the winning ID and clears that source's pending bit. If nothing is eligible, the read returns 0.
- R6: A claimed source shows no pending bit, even while its input stays high, until its ID is written to a claim register. For a level source that is still high, pending returns on the second clock edge after that write.
- R7: Source IDs 9 and 10 are edge-sensitive. A rising edge sets the pending bit, and the bit stays set after the input falls.
- R8: Source IDs 1 to 8 are level-sensitive. While such a source is not claimed, its pending bit follows its input.
- R9: Context 1 is absent. Its interrupt output stays low, writes to its enable and threshold registers are dropped (they read 0), and its claim register reads 0.
- R10: The priority of source n is at word offset 4*n, and the pending word is at 0x1000 with bit n for source n. Read data is registered and appears in the cycle after the read request. A change of input or register state shows on `irq_o` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Source inputs, bit k is source ID k+1 |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 22 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_CTX | One interrupt line per context |

## Verification
Each source's pending state is held in a register. A source input or a register write therefore reaches `irq_o` and the pending word one clock edge later. The bench drives inputs on falling edges and checks the outputs at the next falling edge. A read issued on a falling edge returns its data at the falling edge that follows, so claim results are sampled there. A level source that is re-armed by a completion write needs one further edge to show as pending again, and the bench waits one extra cycle before checking it.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int unsigned ADDR_W     = 22;
   localparam int unsigned PEND_ADDR  = 'h1000;

   typedef enum logic [1:0] {
      GW_IDLE = 2'd0,
      GW_PEND = 2'd1,
      GW_BUSY = 2'd2
   } gw_state_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
   import irq_router_pkg::*;
#(
   parameter bit EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic claim_i,
   input  logic complete_i,
   output logic pend_o,
   output logic busy_o
);
   gw_state_e state_q, state_d;
   logic      trig;

   generate
      if (EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_i;
         end
         assign trig = src_i & ~prev_q;
      end else begin : g_level
         assign trig = src_i;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GW_IDLE: if (trig) state_d = GW_PEND;
         GW_PEND: begin
            if (claim_i)                state_d = GW_BUSY;
            else if (!EDGE && !src_i)   state_d = GW_IDLE;
         end
         GW_BUSY: if (complete_i) state_d = GW_IDLE;
         default: state_d = GW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GW_IDLE;
      else        state_q <= state_d;
   end

   assign pend_o = (state_q == GW_PEND);
   assign busy_o = (state_q == GW_BUSY);

   AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_i && pend_o) |=> busy_o); // R5
   AST_HOLD_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !complete_i) |=> !pend_o); // R6

   generate
      if (EDGE) begin : g_edge_chk
         AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o && !claim_i) |=> pend_o); // R7
      end else begin : g_level_chk
         AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o && !src_i) |=> !pend_o); // R8
      end
   endgenerate
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
   parameter int unsigned NUM_SRC = 10,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ID_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  pend_i,
   input  logic [NUM_SRC-1:0]  en_i,
   input  logic [PRIO_W-1:0]   prio_i [NUM_SRC],
   input  logic [PRIO_W-1:0]   thr_i,
   output logic [ID_W-1:0]     best_id_o,
   output logic                irq_o
);
   logic [PRIO_W-1:0] best_p;

   // ascending scan with strict compare keeps the lowest ID on ties
   always_comb begin
      best_id_o = '0;
      best_p    = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (pend_i[k] && en_i[k] && (prio_i[k] > thr_i) && (prio_i[k] > best_p)) begin
            best_p    = prio_i[k];
            best_id_o = ID_W'(k + 1);
         end
      end
   end

   assign irq_o = (best_id_o != '0);

   AST_IRQ_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (best_p > thr_i)); // R3
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int unsigned          NUM_SRC     = 10,
   parameter int unsigned          NUM_CTX     = 9,
   parameter int unsigned          PRIO_W      = 3,
   parameter logic [NUM_SRC-1:0]   EDGE_MASK   = 10'b11_0000_0000,
   parameter logic [NUM_CTX-1:0]   CTX_PRESENT = 9'b1_1111_1101
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_req_i,
   input  logic               reg_we_i,
   input  logic [21:0]        reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic [NUM_CTX-1:0] irq_o
);
   localparam int unsigned ID_W = $clog2(NUM_SRC + 1);

   generate
      if (NUM_SRC > 31 || NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be 1..31");
      end
      if (NUM_CTX > 64 || NUM_CTX < 1) begin : g_bad_ctx
         $error("NUM_CTX must be 1..64");
      end
      if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
         $error("PRIO_W must be 1..16");
      end
   endgenerate

   logic [PRIO_W-1:0]  prio_q [NUM_SRC];
   logic [NUM_SRC-1:0] en_q   [NUM_CTX];
   logic [PRIO_W-1:0]  thr_q  [NUM_CTX];
   logic [ID_W-1:0]    best_id [NUM_CTX];
   logic [NUM_SRC-1:0] pend, busy, claim_v, complete_v;

   // address decode
   logic       rd, wr, hit_prio, hit_pend, hit_en, hit_ctx, ctx_claim;
   logic [9:0] prio_idx;
   logic [5:0] en_ctx;
   logic [8:0] ctx_field;

   assign rd        = reg_req_i && !reg_we_i;
   assign wr        = reg_req_i &&  reg_we_i;
   assign hit_prio  = (reg_addr_i[21:12] == 10'd0) && (reg_addr_i[1:0] == 2'd0);
   assign prio_idx  = reg_addr_i[11:2];
   assign hit_pend  = (reg_addr_i == 22'(PEND_ADDR));
   assign hit_en    = (reg_addr_i[21:13] == 9'd1) && (reg_addr_i[6:0] == 7'd0);
   assign en_ctx    = reg_addr_i[12:7];
   assign hit_ctx   = reg_addr_i[21] && (reg_addr_i[11:3] == 9'd0) && (reg_addr_i[1:0] == 2'd0);
   assign ctx_field = reg_addr_i[20:12];
   assign ctx_claim = reg_addr_i[2];

   // per-source gateways
   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         irq_gateway #(.EDGE(EDGE_MASK[k])) u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[k]),
            .claim_i    (claim_v[k]),
            .complete_i (complete_v[k]),
            .pend_o     (pend[k]),
            .busy_o     (busy[k])
         );
      end
   endgenerate

   // per-context arbiters, absent slots tied off
   generate
      for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
         if (CTX_PRESENT[c]) begin : g_on
            irq_ctx_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
               .clk       (clk),
               .rst_n     (rst_n),
               .pend_i    (pend),
               .en_i      (en_q[c]),
               .prio_i    (prio_q),
               .thr_i     (thr_q[c]),
               .best_id_o (best_id[c]),
               .irq_o     (irq_o[c])
            );
         end else begin : g_off
            assign best_id[c] = '0;
            assign irq_o[c]   = 1'b0;
         end
      end
   endgenerate

   // claim and complete strobes
   always_comb begin
      claim_v    = '0;
      complete_v = '0;
      for (int c = 0; c < NUM_CTX; c++) begin
         if (CTX_PRESENT[c] && hit_ctx && ctx_claim && ctx_field == 9'(c)) begin
            for (int k = 0; k < NUM_SRC; k++) begin
               if (rd && best_id[c] == ID_W'(k + 1)) claim_v[k] = 1'b1;
               if (wr && reg_wdata_i == 32'(k + 1))  complete_v[k] = 1'b1;
            end
         end
      end
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SRC; k++) prio_q[k] <= '0;
         for (int c = 0; c < NUM_CTX; c++) begin
            en_q[c]  <= '0;
            thr_q[c] <= '0;
         end
      end else if (wr) begin
         for (int k = 0; k < NUM_SRC; k++)
            if (hit_prio && prio_idx == 10'(k + 1)) prio_q[k] <= reg_wdata_i[PRIO_W-1:0];
         for (int c = 0; c < NUM_CTX; c++) begin
            if (CTX_PRESENT[c]) begin
               if (hit_en && en_ctx == 6'(c)) en_q[c] <= reg_wdata_i[NUM_SRC:1];
               if (hit_ctx && !ctx_claim && ctx_field == 9'(c)) thr_q[c] <= reg_wdata_i[PRIO_W-1:0];
            end
         end
      end
   end

   // read path
   logic [31:0] rd_next;
   logic        sel_irq;
   always_comb begin
      rd_next = '0;
      sel_irq = 1'b0;
      if (hit_pend) rd_next[NUM_SRC:1] = pend;
      for (int k = 0; k < NUM_SRC; k++)
         if (hit_prio && prio_idx == 10'(k + 1)) rd_next = 32'(prio_q[k]);
      for (int c = 0; c < NUM_CTX; c++) begin
         if (CTX_PRESENT[c]) begin
            if (hit_en && en_ctx == 6'(c)) rd_next[NUM_SRC:1] = en_q[c];
            if (hit_ctx && ctx_field == 9'(c)) begin
               rd_next = ctx_claim ? 32'(best_id[c]) : 32'(thr_q[c]);
               sel_irq = irq_o[c];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_rdata_o <= '0;
      else if (rd) reg_rdata_o <= rd_next;
   end

   AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim_v)); // R5
   AST_IDLE_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_ctx && ctx_claim && !sel_irq) |=> (reg_rdata_o == 32'd0)); // R5
   AST_CLAIMED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & busy) == '0); // R6
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  src = '0;
   logic        req = 1'b0, we = 1'b0;
   logic [21:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [8:0]  irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   irq_router u_irq_router (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_req_i(req), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   localparam int PEND = 'h1000;
   function automatic int a_prio(int id); return 4 * id; endfunction
   function automatic int a_en(int c);    return 'h2000 + 'h80 * c; endfunction
   function automatic int a_thr(int c);   return 'h200000 + 'h1000 * c; endfunction
   function automatic int a_clm(int c);   return 'h200004 + 'h1000 * c; endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic wr(int a, int d);
      req = 1'b1; we = 1'b1; addr = 22'(a); wdata = 32'(d);
      tick();
      req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      req = 1'b1; we = 1'b0; addr = 22'(a);
      tick();
      req = 1'b0;
      d = int'(rdata);
   endtask

   task automatic t_reset();
      int d;
      check("R1 irq after reset", int'(irq), 0);
      rd(PEND, d);      check("R1 pending after reset", d, 0);
      rd(a_prio(3), d); check("R1 priority after reset", d, 0);
      rd(a_en(0), d);   check("R1 enable after reset", d, 0);
      rd(a_thr(2), d);  check("R1 threshold after reset", d, 0);
   endtask

   task automatic t_priority();
      int d;
      wr(a_prio(3), 5); wr(a_prio(4), 5); wr(a_prio(7), 6);
      rd(a_prio(7), d); check("R10 priority readback", d, 6);
      wr(a_en(0), (1 << 3) | (1 << 4) | (1 << 7));
      src[2] = 1; src[3] = 1; src[6] = 1;
      tick();
      check("R10 irq one edge after input", int'(irq[0]), 1);
      rd(a_clm(0), d); check("R2 highest priority wins", d, 7);
      rd(a_clm(0), d); check("R2 tie goes to lowest ID", d, 3);
      rd(a_clm(0), d); check("R2 next tied source", d, 4);
      rd(a_clm(0), d); check("R5 empty claim reads 0", d, 0);
      check("R5 irq low after all claimed", int'(irq[0]), 0);
      src = '0;
      wr(a_clm(0), 7); wr(a_clm(0), 3); wr(a_clm(0), 4);
      tick();
      rd(PEND, d); check("R8 pending cleared after complete", d, 0);
      wr(a_en(0), 0);
   endtask

   task automatic t_threshold();
      wr(a_prio(2), 2); wr(a_en(2), 1 << 2); wr(a_thr(2), 2);
      src[1] = 1;
      tick();
      check("R3 priority equal to threshold masked", int'(irq[2]), 0);
      wr(a_thr(2), 1);
      check("R3 priority above threshold raises", int'(irq[2]), 1);
      wr(a_thr(2), 0); wr(a_prio(2), 0);
      check("R3 priority 0 never interrupts", int'(irq[2]), 0);
      src[1] = 0;
      wr(a_en(2), 0);
   endtask

   task automatic t_enable();
      int d;
      wr(a_prio(5), 3); wr(a_en(0), 1 << 2); wr(a_en(2), 1 << 5);
      src[4] = 1;
      tick(); tick();
      check("R4 disabled context stays low", int'(irq[0]), 0);
      check("R4 enabled context raised", int'(irq[2]), 1);
      rd(a_clm(2), d); check("R4 claim through enabled context", d, 5);
      src[4] = 0;
      wr(a_clm(2), 5);
      wr(a_en(0), 0); wr(a_en(2), 0);
   endtask

   task automatic t_busy_and_level();
      int d;
      wr(a_prio(6), 1); wr(a_en(0), 1 << 6);
      src[5] = 1;
      tick();
      rd(PEND, d); check("R8 level input sets pending", d, 1 << 6);
      rd(a_clm(0), d); check("R5 claim returns ID", d, 6);
      tick();
      rd(PEND, d); check("R6 claimed source not pending", d, 0);
      check("R6 irq low while claimed", int'(irq[0]), 0);
      wr(a_clm(0), 6);
      tick();
      rd(PEND, d); check("R6 pending returns after complete", d, 1 << 6);
      src[5] = 0;
      tick();
      rd(PEND, d); check("R8 pending follows input low", d, 0);
      wr(a_en(0), 0);
   endtask

   task automatic t_edge();
      int d;
      wr(a_prio(9), 4); wr(a_en(0), 1 << 9);
      src[8] = 1; tick(); src[8] = 0; tick();
      rd(PEND, d); check("R7 edge pending held after fall", d, 1 << 9);
      check("R7 edge source raises irq", int'(irq[0]), 1);
      rd(a_clm(0), d); check("R7 claim edge source", d, 9);
      wr(a_clm(0), 9);
      tick();
      rd(PEND, d); check("R7 no re-pend without new edge", d, 0);
      wr(a_en(0), 0);
   endtask

   task automatic t_absent();
      int d;
      wr(a_prio(1), 7); wr(a_en(1), 'h7FE); wr(a_thr(1), 0);
      src[0] = 1;
      tick();
      check("R9 absent context output low", int'(irq[1]), 0);
      rd(a_en(1), d);  check("R9 absent enable write dropped", d, 0);
      wr(a_thr(1), 3);
      rd(a_thr(1), d); check("R9 absent threshold write dropped", d, 0);
      rd(a_clm(1), d); check("R9 absent claim reads 0", d, 0);
      src[0] = 0;
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_priority();
      t_threshold();
      t_enable();
      t_busy_and_level();
      t_edge();
      t_absent();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule